// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block keeps a short run of instruction bytes ready ahead of execution for a 16-bit processor with segmented addressing. It holds a code segment register and a fetch offset register. From these two registers it forms a 20-bit physical address: the segment value is shifted left by four bits and the offset is added to it. While at least two queue slots are free and the execution side is not holding the bus, the block raises a read request. At an even address the request covers a 16-bit word. At an odd address it covers a single byte.

The returned bytes enter a six-entry first-in first-out queue. The execution side removes bytes from the queue one at a time. A flush input empties the queue and drops the current request. In the same cycle it loads a new segment and offset pair, which is how a taken branch redirects fetching. Reset is qualified: the reset input must stay high for four consecutive clock edges before the block returns to its start vector.

Top module: `ifetch_queue`

## Requirements
- R1: When `rst_in` has been high at four consecutive rising clock edges, the fourth of those edges empties the queue and sets segment FFFFh and offset 0000h. The next request therefore targets physical address FFFF0h as a word fetch.
- R2: A high pulse on `rst_in` that covers only three rising edges has no effect. The queued bytes and the fetch address stay as they were.
- R3: `mem_addr` equals (segment × 16 + offset) modulo 2^20.
- R4: At an even offset a request has `mem_word`=1, and a grant enqueues `mem_rdata[7:0]` first and then `mem_rdata[15:8]`. At an odd offset `mem_word`=0, and a grant enqueues only `mem_rdata[15:8]`. After a grant the offset advances by 2 or by 1, wrapping within 16 bits, and the segment is unchanged.
- R5: The queue holds up to six bytes and releases them in the order they were fetched.
- R6: `mem_req` is high only while at least two queue slots are free. With six or five bytes queued there is no request.
- R7: While `bus_busy` is high, `mem_req` stays low. A `mem_gnt` in that state enqueues nothing and does not move the offset. The request returns once `bus_busy` falls.
- R8: With the queue empty, `pop_valid`=0 and `pop_data`=00h. A `pop_req` in that state changes nothing.
- R9: A cycle with `flush` high shows no request and no valid byte. At the next cycle the queue is empty and fetching restarts at `flush_seg`:`flush_off`, even if `mem_gnt` was high during the flush cycle.
- R10: A grant and a pop in the same cycle both take effect. The popped byte is the oldest byte, and the new bytes queue behind the bytes that remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_in | input | 1 | Reset request, qualified over four edges |
| bus_busy | input | 1 | Execution side holds the bus; no fetch request is raised |
| mem_req | output | 1 | Fetch read request |
| mem_addr | output | 20 | Physical fetch address |
| mem_word | output | 1 | 1: fetch a 16-bit word, 0: fetch a single byte |
| mem_gnt | input | 1 | Grant; read data is valid in the same cycle |
| mem_rdata | input | 16 | Read data; the byte at the odd address is on bits 15:8 |
| pop_req | input | 1 | Execution side takes the head byte |
| pop_valid | output | 1 | Head byte is valid |
| pop_data | output | 8 | Head byte, 00h when not valid |
| flush | input | 1 | Empty the queue and redirect fetching |
| flush_seg | input | 16 | New code segment loaded on flush |
| flush_off | input | 16 | New fetch offset loaded on flush |

## Verification
Address formation is driven with a table of segment and offset pairs. The table includes pairs whose sum carries past bit 19 and both offset parities, which separates a correct shift-and-add from a concatenation and separates word fetches from byte fetches. Directed sequences fill the queue to six and then drain it. This exposes the order of bytes within a word, a wrong free-slot threshold, and stale data on an empty pop. Further sequences overlap a grant with a pop, a grant with a flush, and a grant with `bus_busy`, which separates correct priority from lost or phantom bytes. Reset pulses of three and of four edges show whether the qualification counter sits at the right length.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

   // number of bytes a single grant places into the queue
   typedef enum logic [1:0] {
      PUSH_NONE = 2'd0,
      PUSH_ONE  = 2'd1,
      PUSH_TWO  = 2'd2
   } push_e;

endpackage

// File: rtl/ifq_rst_filter.sv
module ifq_rst_filter #(
   parameter int RST_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_in,
   output logic core_rst
);
   localparam int CW = $clog2(RST_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

   if (RST_CYCLES < 2) begin : g_bad_len
      $error("ifq_rst_filter: RST_CYCLES must be at least 2");
   end

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_in)
         run_cnt <= '0;
      else if (run_cnt != LAST)
         run_cnt <= run_cnt + 1'b1;
   end

   // the qualifying edge is the one at which the run reaches RST_CYCLES
   assign core_rst = rst_in && (run_cnt == LAST);

   // R2: a qualified reset always follows at least two high samples
   assert_rst_qualified_R2: assert property (@(posedge clk)
      core_rst |-> (rst_in && $past(rst_in)));

endmodule

// File: rtl/ifq_addr_gen.sv
module ifq_addr_gen #(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter int SHIFT = 4,
   parameter int PA_W  = 20
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [OFF_W-1:0] off,
   output logic [PA_W-1:0]  phys
);
   if (SEG_W + SHIFT != PA_W) begin : g_bad_seg
      $error("ifq_addr_gen: SEG_W + SHIFT must equal PA_W");
   end
   if (OFF_W > PA_W) begin : g_bad_off
      $error("ifq_addr_gen: OFF_W must not exceed PA_W");
   end

   logic [PA_W-1:0] base;

   always_comb begin
      base = {seg, {SHIFT{1'b0}}};
      phys = base + PA_W'(off);   // carry out of the top bit is dropped
   end

endmodule

// File: rtl/ifq_fifo.sv
module ifq_fifo
   import ifq_pkg::*;
#(
   parameter int DEPTH = 6,
   parameter int W     = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          flush,
   input  push_e         push_n,
   input  logic [W-1:0]  push_d0,
   input  logic [W-1:0]  push_d1,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic          empty,
   output logic [LW-1:0] level
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("ifq_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  slot [DEPTH];
   logic [PW-1:0] rd_p, wr_p, wr_p1;
   logic          do_pop;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign wr_p1  = bump(wr_p);
   assign do_pop = pop && (level != '0);
   assign empty  = (level == '0);
   assign head   = slot[rd_p];

   // one writer per slot: first byte at the tail, second byte just behind it
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push_n != PUSH_NONE && wr_p == PW'(i))
            slot[i] <= push_d0;
         else if (push_n == PUSH_TWO && wr_p1 == PW'(i))
            slot[i] <= push_d1;
      end
   end

   always_ff @(posedge clk) begin
      if (clr || flush) begin
         rd_p  <= '0;
         wr_p  <= '0;
         level <= '0;
      end else begin
         case (push_n)
            PUSH_ONE: wr_p <= wr_p1;
            PUSH_TWO: wr_p <= bump(wr_p1);
            default:  wr_p <= wr_p;
         endcase
         if (do_pop)
            rd_p <= bump(rd_p);
         level <= level + LW'(push_n) - LW'(do_pop);
      end
   end

   // R5: a push never needs more room than is free
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (clr)
      (32'(level) + 32'(push_n) <= DEPTH));

   // R8: popping an empty queue with nothing arriving leaves it empty
   assert_empty_pop_R8: assert property (@(posedge clk) disable iff (clr)
      (empty && !flush && push_n == PUSH_NONE) |=> empty);

endmodule

// File: rtl/ifetch_queue.sv
module ifetch_queue
   import ifq_pkg::*;
#(
   parameter int          DEPTH      = 6,
   parameter int          MIN_FREE   = 2,
   parameter int          RST_CYCLES = 4,
   parameter bit          WORD_FETCH = 1'b1,
   parameter logic [15:0] RESET_SEG  = 16'hFFFF,
   parameter logic [15:0] RESET_OFF  = 16'h0000
) (
   input  logic        clk,
   input  logic        rst_in,
   input  logic        bus_busy,
   output logic        mem_req,
   output logic [19:0] mem_addr,
   output logic        mem_word,
   input  logic        mem_gnt,
   input  logic [15:0] mem_rdata,
   input  logic        pop_req,
   output logic        pop_valid,
   output logic [7:0]  pop_data,
   input  logic        flush,
   input  logic [15:0] flush_seg,
   input  logic [15:0] flush_off
);
   localparam int LW = $clog2(DEPTH + 1);
   localparam logic [19:0] RESET_PA = {RESET_SEG, 4'h0} + 20'(RESET_OFF);

   if (MIN_FREE < (WORD_FETCH ? 2 : 1) || MIN_FREE > DEPTH) begin : g_bad_free
      $error("ifetch_queue: MIN_FREE must cover one fetch and fit in DEPTH");
   end

   logic          core_rst;
   logic [15:0]   seg_q, off_q;
   logic [LW-1:0] level;
   logic          empty, taken, room;
   logic [7:0]    head, byte_lane, push_d0;
   push_e         push_n;

   ifq_rst_filter #(.RST_CYCLES(RST_CYCLES)) u_rst (
      .clk(clk), .rst_in(rst_in), .core_rst(core_rst));

   ifq_addr_gen #(.SEG_W(16), .OFF_W(16), .SHIFT(4), .PA_W(20)) u_addr (
      .seg(seg_q), .off(off_q), .phys(mem_addr));

   // fetch-width variant: word at even offsets, or single bytes throughout
   if (WORD_FETCH) begin : g_word
      assign mem_word = ~off_q[0];
   end else begin : g_byte
      assign mem_word = 1'b0;
   end

   assign room      = (32'(level) + MIN_FREE <= DEPTH);
   assign mem_req   = !core_rst && !flush && !bus_busy && room;
   assign taken     = mem_req && mem_gnt;
   assign byte_lane = off_q[0] ? mem_rdata[15:8] : mem_rdata[7:0];
   assign push_d0   = mem_word ? mem_rdata[7:0] : byte_lane;
   assign push_n    = !taken ? PUSH_NONE : (mem_word ? PUSH_TWO : PUSH_ONE);

   assign pop_valid = !empty && !flush;
   assign pop_data  = pop_valid ? head : 8'h00;

   ifq_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
      .clk(clk), .clr(core_rst), .flush(flush),
      .push_n(push_n), .push_d0(push_d0), .push_d1(mem_rdata[15:8]),
      .pop(pop_req && pop_valid),
      .head(head), .empty(empty), .level(level));

   always_ff @(posedge clk) begin
      if (core_rst) begin
         seg_q <= RESET_SEG;
         off_q <= RESET_OFF;
      end else if (flush) begin
         seg_q <= flush_seg;
         off_q <= flush_off;
      end else if (taken) begin
         off_q <= off_q + (mem_word ? 16'd2 : 16'd1);
      end
   end

   // R1: reset lands the fetch pointer on the start vector
   assert_reset_vector_R1: assert property (@(posedge clk)
      core_rst |=> (mem_addr == RESET_PA));

   // R4: every accepted fetch leaves at least one byte queued
   assert_grant_fills_R4: assert property (@(posedge clk) disable iff (core_rst)
      (mem_req && mem_gnt) |=> !empty);

   // R7: the fetch offset holds while the execution side owns the bus
   assert_bus_yield_R7: assert property (@(posedge clk) disable iff (core_rst)
      (bus_busy && !flush) |=> $stable(off_q));

   // R9: a flush leaves nothing queued
   assert_flush_empties_R9: assert property (@(posedge clk) disable iff (core_rst)
      flush |=> empty);

endmodule

// File: tb/ifetch_queue_bench.sv
module ifetch_queue_bench;
   localparam int PERIOD = 10;
   localparam int WATCHDOG = 5000;

   // {segment, offset, expected address, expected word flag}
   localparam logic [52:0] VEC [0:5] = '{
      {16'h1234, 16'h5678, 20'h179B8, 1'b1},
      {16'h0000, 16'h0001, 20'h00001, 1'b0},
      {16'hABCD, 16'h000F, 20'hABCDF, 1'b0},
      {16'h8000, 16'hFFFE, 20'h8FFFE, 1'b1},
      {16'hFFFF, 16'hFFFF, 20'h0FFEF, 1'b0},
      {16'hF000, 16'h1003, 20'hF1003, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_in = 1'b0, bus_busy = 1'b0, mem_gnt = 1'b0;
   logic        pop_req = 1'b0, flush = 1'b0;
   logic [15:0] mem_rdata = '0, flush_seg = '0, flush_off = '0;
   logic        mem_req, mem_word, pop_valid;
   logic [19:0] mem_addr;
   logic [7:0]  pop_data;
   int          checks = 0, bad = 0;

   always #(PERIOD / 2) clk = ~clk;

   ifetch_queue u_ifetch_queue (
      .clk(clk), .rst_in(rst_in), .bus_busy(bus_busy),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_word(mem_word),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
      .flush(flush), .flush_seg(flush_seg), .flush_off(flush_off));

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic grant(input logic [15:0] d, input logic [19:0] ea, input logic ew, input string tag);
      mem_gnt = 1'b1;
      mem_rdata = d;
      #1;
      chk({tag, " req"}, 32'(mem_req), 32'd1);
      chk({tag, " addr"}, 32'(mem_addr), 32'(ea));
      chk({tag, " word"}, 32'(mem_word), 32'(ew));
      step();
      mem_gnt = 1'b0;
   endtask

   task automatic pop(input logic [7:0] eb, input string tag);
      pop_req = 1'b1;
      #1;
      chk({tag, " valid"}, 32'(pop_valid), 32'd1);
      chk({tag, " data"}, 32'(pop_data), 32'(eb));
      step();
      pop_req = 1'b0;
   endtask

   task automatic do_flush(input logic [15:0] s, input logic [15:0] o, input string tag);
      flush = 1'b1;
      flush_seg = s;
      flush_off = o;
      #1;
      chk({tag, " no req in flush"}, 32'(mem_req), 32'd0);
      step();
      flush = 1'b0;
      #1;
   endtask

   task automatic reset_run(input int n);
      rst_in = 1'b1;
      for (int i = 0; i < n; i++) step();
      rst_in = 1'b0;
      #1;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
      finish_run();
   end

   initial begin
      step();
      // R1: four-edge reset reaches the start vector
      reset_run(4);
      chk("R1 req", 32'(mem_req), 32'd1);
      chk("R1 addr", 32'(mem_addr), 32'h000FFFF0);
      chk("R1 word", 32'(mem_word), 32'd1);
      chk("R1 empty", 32'(pop_valid), 32'd0);

      // R4/R5: fill with three words, lane order low then high
      grant(16'hB2A1, 20'hFFFF0, 1'b1, "R4 g0");
      grant(16'hD4C3, 20'hFFFF2, 1'b1, "R4 g1");
      grant(16'hF6E5, 20'hFFFF4, 1'b1, "R5 g2");
      #1;
      chk("R6 full no req", 32'(mem_req), 32'd0);
      pop(8'hA1, "R5 p0");
      #1;
      chk("R6 one free no req", 32'(mem_req), 32'd0);
      pop(8'hB2, "R5 p1");
      #1;
      chk("R6 two free req", 32'(mem_req), 32'd1);
      chk("R6 two free addr", 32'(mem_addr), 32'h000FFFF6);
      pop(8'hC3, "R5 p2");
      pop(8'hD4, "R5 p3");
      pop(8'hE5, "R5 p4");
      pop(8'hF6, "R5 p5");

      // R8: empty pop returns nothing and changes nothing
      bus_busy = 1'b1;
      pop_req = 1'b1;
      #1;
      chk("R8 valid", 32'(pop_valid), 32'd0);
      chk("R8 data", 32'(pop_data), 32'h0);
      step();
      pop_req = 1'b0;
      bus_busy = 1'b0;
      #1;
      chk("R8 still empty", 32'(pop_valid), 32'd0);
      chk("R8 addr kept", 32'(mem_addr), 32'h000FFFF6);

      // R4: odd offset fetches a byte from the high lane
      do_flush(16'h1000, 16'h0003, "R9 f0");
      grant(16'h7F11, 20'h10003, 1'b0, "R4 odd");
      // R10: grant and pop together
      mem_gnt = 1'b1;
      mem_rdata = 16'h2211;
      pop_req = 1'b1;
      #1;
      chk("R10 addr", 32'(mem_addr), 32'h00010004);
      chk("R10 head", 32'(pop_data), 32'h7F);
      step();
      mem_gnt = 1'b0;
      pop_req = 1'b0;
      pop(8'h11, "R10 p0");
      pop(8'h22, "R10 p1");

      // R7: bus held by execution side
      bus_busy = 1'b1;
      #1;
      chk("R7 no req", 32'(mem_req), 32'd0);
      mem_gnt = 1'b1;
      mem_rdata = 16'h9988;
      step();
      mem_gnt = 1'b0;
      #1;
      chk("R7 nothing queued", 32'(pop_valid), 32'd0);
      chk("R7 addr kept", 32'(mem_addr), 32'h00010006);
      bus_busy = 1'b0;
      #1;
      chk("R7 resumes", 32'(mem_req), 32'd1);

      // R9: flush with a grant in the same cycle drops it
      grant(16'h4433, 20'h10006, 1'b1, "R9 pre");
      flush = 1'b1;
      flush_seg = 16'h3000;
      flush_off = 16'h0010;
      mem_gnt = 1'b1;
      mem_rdata = 16'h6655;
      #1;
      chk("R9 no valid in flush", 32'(pop_valid), 32'd0);
      step();
      flush = 1'b0;
      mem_gnt = 1'b0;
      #1;
      chk("R9 emptied", 32'(pop_valid), 32'd0);
      chk("R9 new addr", 32'(mem_addr), 32'h00030010);

      // R4: offset wraps inside the segment
      do_flush(16'h2000, 16'hFFFF, "R9 f1");
      grant(16'h5A00, 20'h2FFFF, 1'b0, "R4 wrap");
      #1;
      chk("R4 wrap addr", 32'(mem_addr), 32'h00020000);

      // R2: three-edge pulse is ignored
      reset_run(3);
      chk("R2 addr kept", 32'(mem_addr), 32'h00020000);
      chk("R2 queue kept", 32'(pop_valid), 32'd1);
      chk("R2 head kept", 32'(pop_data), 32'h5A);
      reset_run(4);
      chk("R1 again addr", 32'(mem_addr), 32'h000FFFF0);
      chk("R1 again empty", 32'(pop_valid), 32'd0);

      // R3: address formation table
      for (int i = 0; i < 6; i++) begin
         do_flush(VEC[i][52:37], VEC[i][36:21], "R3 tbl");
         chk($sformatf("R3 vec%0d addr", i), 32'(mem_addr), 32'(VEC[i][20:1]));
         chk($sformatf("R3 vec%0d word", i), 32'(mem_word), 32'(VEC[i][0]));
      end

      finish_run();
   end

endmodule